// File: doc/BRIEF.md
# Row-and-Column Parity Block Codec

This block guards a block of characters on a byte-wide stream with a two-dimensional parity scheme. In encode mode it tags every character with its own parity bit. After the last character of the block it emits one extra check word. Bit b of that word covers bit position b across every character of the block. Its top bit is a corner bit: the parity of the check word's own data bits. An m-character block of W-bit data therefore carries m + W + 1 parity bits.

In check mode the same port takes the coded characters, each with its received parity bit, followed by the check word. One cycle after the check word the block reports its findings. Any failing row or failing column is an error. Exactly one failing row together with exactly one failing column gives the position of the single bad bit and the repaired character. Every other error pattern is marked uncorrectable. A mismatch of the corner bit is reported on a flag of its own. The parity sense (even or odd) is chosen per block by an input.

Top module: `twodpar_codec`

## Requirements
- R1: Out of reset `out_valid` and `res_valid` are low. In encode mode (`in_mode`=0), one cycle after each accepted character, `out_valid`=1, `out_chk`=0, `out_char[W-1:0]` equals the data, and `out_char[W]` is the bit that makes the count of ones in `out_char` even (`in_odd`=0) or odd (`in_odd`=1).
- R2: In encode mode, two cycles after the character marked `in_last`, `out_valid`=1 and `out_chk`=1. For each b, `out_char[b]` makes the count of ones in bit b over all data characters plus that bit match the parity sense.
- R3: The top bit `out_char[W]` of the check word makes the count of ones in the whole check word match the same parity sense as the rows.
- R4: In check mode (`in_mode`=1), the word marked `in_last` is the check word, with its top bit on `in_pbit`. One cycle later `res_valid` pulses. `res_err`=1 exactly when some data row or some column fails its parity.
- R5: When exactly one data row and exactly one column fail, `res_corr`=1. `res_row` is the zero-based count of that character from the start of the block. `res_col` is the bit position. `res_fix` is that character's data with that bit inverted.
- R6: When `res_err`=1 and R5 does not apply (including every double-bit error), `res_uncorr`=1, `res_corr`=0, and `res_row`, `res_col` and `res_fix` are zero.
- R7: `res_cbe`=1 when the check word's own parity (data bits plus `in_pbit`) fails. A corner mismatch alone leaves `res_err`=0.
- R8: All accumulators clear on the cycle after `in_last`, so a following block may start on the very next cycle in check mode and is judged alone.
- R9: A block holds up to `MAX_CHARS` data characters. The row index reaches `MAX_CHARS`-1.
- R10: In encode mode `in_pbit` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A character is present this cycle |
| in_mode | input | 1 | 0 encode, 1 check; held for a whole block |
| in_odd | input | 1 | Parity sense: 0 even, 1 odd; held for a whole block |
| in_last | input | 1 | Marks the last data character (encode) or the check word (check) |
| in_data | input | W | Character data bits |
| in_pbit | input | 1 | Received parity bit (check mode only) |
| out_valid | output | 1 | Coded word on `out_char` |
| out_chk | output | 1 | The coded word is the check word |
| out_char | output | W+1 | Parity bit on top, data below |
| res_valid | output | 1 | Check results valid this cycle |
| res_err | output | 1 | Some row or column failed |
| res_corr | output | 1 | Single bad bit located |
| res_uncorr | output | 1 | Error that cannot be located |
| res_cbe | output | 1 | Corner bit mismatch |
| res_row | output | clog2(MAX_CHARS) | Row of the bad bit |
| res_col | output | clog2(W) | Column of the bad bit |
| res_fix | output | W | Repaired character |

## Verification
The assertions rely on three rules for the inputs. In encode mode the sender stays idle for the one cycle after `in_last`, while the check word goes out. No block has more than `MAX_CHARS` data characters. The mode and the parity sense stay fixed inside a block. The stimulus holds `in_valid` low in the cycle after every encode block and never exceeds the length limit. It changes mode and sense only between blocks. Check-mode blocks are sometimes chained with no idle cycle, which the rules allow.

// File: rtl/twodpar_codec.sv
module twodpar_codec #(
  parameter int W         = 8,
  parameter int MAX_CHARS = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         in_mode,
  input  logic                         in_odd,
  input  logic                         in_last,
  input  logic [W-1:0]                 in_data,
  input  logic                         in_pbit,
  output logic                         out_valid,
  output logic                         out_chk,
  output logic [W:0]                   out_char,
  output logic                         res_valid,
  output logic                         res_err,
  output logic                         res_corr,
  output logic                         res_uncorr,
  output logic                         res_cbe,
  output logic [$clog2(MAX_CHARS)-1:0] res_row,
  output logic [$clog2(W)-1:0]         res_col,
  output logic [W-1:0]                 res_fix
);
  localparam int RW = $clog2(MAX_CHARS);
  localparam int CW = $clog2(W);

  logic [W-1:0]  col_q;
  logic [RW:0]   cnt_q;
  logic [1:0]    rfail_q;
  logic [RW-1:0] frow_q;
  logic [W-1:0]  fdata_q;
  logic          pend_q;
  logic          pend_odd_q;
  logic [W-1:0]  pend_chk_q;

  wire          row_par = (^in_data) ^ in_odd;
  wire          row_bad = (^in_data) ^ in_pbit ^ in_odd;
  wire [W-1:0]  col_next = col_q ^ in_data;
  wire [W-1:0]  tx_chk = col_next ^ {W{in_odd}};
  wire [W-1:0]  col_bad = col_q ^ in_data ^ {W{in_odd}};
  wire          any_err = (rfail_q != 2'd0) || (|col_bad);
  wire          one_hit = (rfail_q == 2'd1) && ($countones(col_bad) == 1);

  logic [CW-1:0] bcol;
  always_comb begin
    bcol = '0;
    for (int b = W-1; b >= 0; b--)
      if (col_bad[b]) bcol = CW'(b);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q      <= '0;
      cnt_q      <= '0;
      rfail_q    <= '0;
      frow_q     <= '0;
      fdata_q    <= '0;
      pend_q     <= 1'b0;
      pend_odd_q <= 1'b0;
      pend_chk_q <= '0;
      out_valid  <= 1'b0;
      out_chk    <= 1'b0;
      out_char   <= '0;
      res_valid  <= 1'b0;
      res_err    <= 1'b0;
      res_corr   <= 1'b0;
      res_uncorr <= 1'b0;
      res_cbe    <= 1'b0;
      res_row    <= '0;
      res_col    <= '0;
      res_fix    <= '0;
    end else begin
      out_valid <= 1'b0;
      out_chk   <= 1'b0;
      res_valid <= 1'b0;
      if (pend_q) begin
        out_valid <= 1'b1;
        out_chk   <= 1'b1;
        out_char  <= {(^pend_chk_q) ^ pend_odd_q, pend_chk_q};
        pend_q    <= 1'b0;
      end
      if (in_valid) begin
        if (in_last) begin
          col_q   <= '0;
          cnt_q   <= '0;
          rfail_q <= '0;
        end else begin
          col_q <= col_next;
          cnt_q <= cnt_q + 1'b1;
          if (in_mode && row_bad) begin
            if (rfail_q == 2'd0) begin
              frow_q  <= cnt_q[RW-1:0];
              fdata_q <= in_data;
            end
            if (rfail_q != 2'd2) rfail_q <= rfail_q + 1'b1;
          end
        end
        if (!in_mode) begin
          out_valid <= 1'b1;
          out_char  <= {row_par, in_data};
          if (in_last) begin
            pend_q     <= 1'b1;
            pend_chk_q <= tx_chk;
            pend_odd_q <= in_odd;
          end
        end else if (in_last) begin
          res_valid  <= 1'b1;
          res_err    <= any_err;
          res_corr   <= one_hit;
          res_uncorr <= any_err && !one_hit;
          res_cbe    <= row_bad;
          res_row    <= one_hit ? frow_q : '0;
          res_col    <= one_hit ? bcol : '0;
          res_fix    <= one_hit ? (fdata_q ^ (W'(1) << bcol)) : '0;
        end
      end
    end
  end

  AST_TX_ROW_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_chk) |-> ((^out_char) == $past(in_odd))); // R1
  AST_CHK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_chk |-> $past(in_valid && in_last && !in_mode, 2)); // R2
  AST_CHK_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
    out_chk |-> ((^out_char) == $past(in_odd, 2))); // R3
  AST_RES_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_last && in_mode)); // R4
  AST_TX_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !in_valid); // R2
  AST_BLK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_last) |-> (cnt_q < (RW+1)'(MAX_CHARS))); // R9
endmodule

// File: tb/twodpar_codec_bench.sv
module twodpar_codec_bench;
  localparam int W = 8;
  localparam int MAXC = 64;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_mode = 1'b0, in_odd = 1'b0, in_last = 1'b0, in_pbit = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_valid, out_chk, res_valid, res_err, res_corr, res_uncorr, res_cbe;
  logic [W:0] out_char;
  logic [5:0] res_row;
  logic [2:0] res_col;
  logic [W-1:0] res_fix;

  always #5 clk = ~clk;

  twodpar_codec #(.W(W), .MAX_CHARS(MAXC)) u_twodpar_codec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode), .in_odd(in_odd),
    .in_last(in_last), .in_data(in_data), .in_pbit(in_pbit), .out_valid(out_valid),
    .out_chk(out_chk), .out_char(out_char), .res_valid(res_valid), .res_err(res_err),
    .res_corr(res_corr), .res_uncorr(res_uncorr), .res_cbe(res_cbe), .res_row(res_row),
    .res_col(res_col), .res_fix(res_fix));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] d [MAXC];
  logic [W:0] rx [MAXC+1];

  // data[55:24] odd[23] fa_en[22] fa_row[21:19] fa_col[18:15] fb_en[14] fb_row[13:11] fb_col[10:7]
  localparam logic [55:0] VEC [9] = '{
    {32'h12345678, 1'b0, 1'b0, 3'd0, 4'd0, 1'b0, 3'd0, 4'd0, 7'd0},
    {32'hFF00A55A, 1'b1, 1'b0, 3'd0, 4'd0, 1'b0, 3'd0, 4'd0, 7'd0},
    {32'hC3E10F99, 1'b0, 1'b1, 3'd1, 4'd2, 1'b0, 3'd0, 4'd0, 7'd0},
    {32'h01020408, 1'b1, 1'b1, 3'd3, 4'd7, 1'b0, 3'd0, 4'd0, 7'd0},
    {32'hDEADBEEF, 1'b0, 1'b1, 3'd0, 4'd1, 1'b1, 3'd0, 4'd5, 7'd0},
    {32'h55AA33CC, 1'b1, 1'b1, 3'd1, 4'd4, 1'b1, 3'd2, 4'd4, 7'd0},
    {32'h0F1E2D3C, 1'b0, 1'b1, 3'd4, 4'd8, 1'b0, 3'd0, 4'd0, 7'd0},
    {32'h80402010, 1'b1, 1'b1, 3'd2, 4'd8, 1'b0, 3'd0, 4'd0, 7'd0},
    {32'h6699F00F, 1'b0, 1'b1, 3'd4, 4'd3, 1'b0, 3'd0, 4'd0, 7'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at a negedge with inputs idle
  task automatic do_encode(input int n, input bit odd);
    logic [W-1:0] colx = '0;
    logic [W-1:0] ck;
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        @(negedge clk);
        chk(out_valid && !out_chk && out_char == {(^d[i-1]) ^ odd, d[i-1]}, "R1 R10 coded char",
            {out_valid, out_chk, out_char}, {2'b10, (^d[i-1]) ^ odd, d[i-1]});
      end
      in_valid = 1'b1; in_mode = 1'b0; in_odd = odd; in_data = d[i];
      in_pbit = 1'($urandom); in_last = (i == n-1);
      colx ^= d[i];
      rx[i] = {(^d[i]) ^ odd, d[i]};
    end
    @(negedge clk);
    chk(out_valid && !out_chk && out_char == rx[n-1], "R1 R10 coded char",
        {out_valid, out_chk, out_char}, {2'b10, rx[n-1]});
    in_valid = 1'b0; in_last = 1'b0;
    ck = colx ^ {W{odd}};
    rx[n] = {(^ck) ^ odd, ck};
    @(negedge clk);
    chk(out_valid && out_chk && out_char[W-1:0] == ck, "R2 check word",
        {out_valid, out_chk, out_char}, {2'b11, rx[n]});
    chk(out_char[W] == rx[n][W], "R3 corner bit", 32'(out_char[W]), 32'(rx[n][W]));
  endtask

  // called at a negedge; returns at the negedge where results are visible
  task automatic do_receive(input int n, input bit odd);
    int nr = 0;
    int fr = 0;
    logic [W-1:0] colx = '0;
    logic [W-1:0] cb;
    bit err, corr, cf;
    int bc = 0;
    for (int i = 0; i <= n; i++) begin
      if (i > 0) @(negedge clk);
      in_valid = 1'b1; in_mode = 1'b1; in_odd = odd;
      in_data = rx[i][W-1:0]; in_pbit = rx[i][W]; in_last = (i == n);
    end
    for (int i = 0; i < n; i++) begin
      if ((^rx[i]) ^ odd) begin
        if (nr == 0) fr = i;
        nr++;
      end
      colx ^= rx[i][W-1:0];
    end
    cb = colx ^ rx[n][W-1:0] ^ {W{odd}};
    for (int b = 0; b < W; b++) if (cb[b]) bc = b;
    cf = (^rx[n]) ^ odd;
    err = (nr > 0) || (cb != 0);
    corr = (nr == 1) && ($countones(cb) == 1);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk(res_valid, "R4 result strobe", 32'(res_valid), 1);
    chk(res_err == err, "R4 error flag", 32'(res_err), 32'(err));
    chk(res_corr == corr, "R5 corrected flag", 32'(res_corr), 32'(corr));
    chk(res_uncorr == (err && !corr), "R6 uncorrectable flag", 32'(res_uncorr), 32'(err && !corr));
    chk(res_cbe == cf, "R7 corner flag", 32'(res_cbe), 32'(cf));
    if (corr)
      chk(res_row == 6'(fr) && res_col == 3'(bc) && res_fix == (rx[fr][W-1:0] ^ cb), "R5 location",
          {res_row, res_col, res_fix}, {6'(fr), 3'(bc), rx[fr][W-1:0] ^ cb});
    else
      chk(res_row == 0 && res_col == 0 && res_fix == 0, "R6 no location",
          {res_row, res_col, res_fix}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !res_valid, "R1 reset state", {out_valid, res_valid}, 0);

    for (int v = 0; v < 9; v++) begin
      logic [55:0] e = VEC[v];
      for (int i = 0; i < N; i++) d[i] = e[55-8*i -: 8];
      do_encode(N, e[23]);
      if (e[22]) rx[e[21:19]][e[18:15]] ^= 1'b1;
      if (e[14]) rx[e[13:11]][e[10:7]] ^= 1'b1;
      do_receive(N, e[23]);
      @(negedge clk);
    end

    // R9: full-length block, single error in the last row
    for (int i = 0; i < MAXC; i++) d[i] = 8'(i * 37 + 5);
    do_encode(MAXC, 1'b1);
    rx[MAXC-1][7] ^= 1'b1;
    do_receive(MAXC, 1'b1);
    chk(res_corr && res_row == 6'(MAXC-1), "R9 last row index", {res_corr, res_row}, {1'b1, 6'(MAXC-1)});

    // R8: a double-error block followed at once by a clean block
    @(negedge clk);
    for (int i = 0; i < N; i++) d[i] = 8'hA0 + 8'(i);
    do_encode(N, 1'b0);
    rx[0][0] ^= 1'b1; rx[3][0] ^= 1'b1;
    do_receive(N, 1'b0);
    chk(res_uncorr, "R8 first block uncorrectable", 32'(res_uncorr), 1);
    rx[0][0] ^= 1'b1; rx[3][0] ^= 1'b1;
    do_receive(N, 1'b0);
    chk(!res_err && !res_cbe, "R8 chained clean block", {res_err, res_cbe}, 0);

    // R7: corner alone, odd sense
    @(negedge clk);
    do_encode(N, 1'b1);
    rx[N][W] ^= 1'b1;
    do_receive(N, 1'b1);
    chk(res_cbe && !res_err, "R7 corner only", {res_cbe, res_err}, 2'b10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule